// File: doc/BRIEF.md
# Microprogram Address Sequencer

This block chooses the next micro-state of a microcoded control unit. It holds a small micro-state register. Every micro-state has a 2-bit address-control code in a per-state control store. Each cycle that code picks the next state from one of four sources:

- zero, which returns to the fetch state;
- the first dispatch table, indexed by the 6-bit opcode;
- the second dispatch table, also indexed by the opcode;
- the current state plus one.

The opcode comes straight from the instruction register and has an effect only in the two dispatch states. The host controller uses the state output to drive its wide datapath control word. It keeps the opcode steady for as long as an instruction is in flight.

Top module: `mseq_sequencer`

## Requirements
- R1: A synchronous active-high reset loads micro-state 0 on the next rising edge, whatever the current state or opcode.
- R2: The address-control output is 3 in states 0, 3 and 6; 1 in state 1; 2 in state 2; and 0 in states 4, 5, 7, 8 and 9 and in every unused state. The encoding is 0 = zero, 1 = first table, 2 = second table, 3 = increment.
- R3: When the address-control code is 3, the next state is the current state plus one.
- R4: When the address-control code is 0, the next state is 0.
- R5: In state 1 the first table sends opcode 000000 to state 6, 000010 to state 9, 000100 to state 8, and both 100011 and 101011 to state 2.
- R6: In state 2 the second table sends opcode 100011 to state 3 and 101011 to state 5.
- R7: An opcode that is not in the table being consulted sends the sequencer to state 0.
- R8: With a steady opcode the state sequences are: 100011 gives 0-1-2-3-4-0; 101011 gives 0-1-2-5-0; 000000 gives 0-1-6-7-0; 000100 gives 0-1-8-0; 000010 gives 0-1-9-0.
- R9: The opcode has no effect on the next state in any state whose code is 0 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field from the instruction register |
| state_o | output | 4 | Current micro-state |
| addr_ctrl_o | output | 2 | Address-control code of the current state |

## Verification
The hardest case to reach is a miss in the second table. State 2 can only be entered with a load or store opcode, and both of those are present in the second table. To make the miss happen, the stimulus enters state 2 with a load opcode. In the cycle the sequencer sits in state 2, it swaps the opcode to an R-type value, which the second table does not hold, and then expects a return to state 0. In the same way, the stimulus changes the opcode while the sequencer is in zero-code and increment states, to show that it is ignored there.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
   typedef enum logic [1:0] {
      SEL_ZERO   = 2'd0,
      SEL_DISP_A = 2'd1,
      SEL_DISP_B = 2'd2,
      SEL_INCR   = 2'd3
   } addr_sel_e;

   localparam logic [5:0] OPC_RTYPE = 6'b000000;
   localparam logic [5:0] OPC_JUMP  = 6'b000010;
   localparam logic [5:0] OPC_BEQ   = 6'b000100;
   localparam logic [5:0] OPC_LOAD  = 6'b100011;
   localparam logic [5:0] OPC_STORE = 6'b101011;
endpackage

// File: rtl/mseq_ctrl_store.sv
module mseq_ctrl_store
   import mseq_pkg::*;
#(
   parameter int unsigned ST_W = 4
) (
   input  logic [ST_W-1:0] state,
   output addr_sel_e       sel
);
   always_comb begin
      case (state)
         ST_W'(0): sel = SEL_INCR;
         ST_W'(1): sel = SEL_DISP_A;
         ST_W'(2): sel = SEL_DISP_B;
         ST_W'(3): sel = SEL_INCR;
         ST_W'(6): sel = SEL_INCR;
         default:  sel = SEL_ZERO;
      endcase
   end
endmodule

// File: rtl/mseq_dispatch.sv
module mseq_dispatch
   import mseq_pkg::*;
#(
   parameter int unsigned ST_W     = 4,
   parameter int unsigned OP_W     = 6,
   parameter int unsigned TABLE_ID = 1
) (
   input  logic [OP_W-1:0] opcode,
   output logic [ST_W-1:0] target
);
   localparam int unsigned OP_PAD = OP_W - 6;

   logic [5:0] op_low;
   logic       upper_clear;

   assign op_low      = opcode[5:0];
   assign upper_clear = (OP_PAD == 0) ? 1'b1 : (opcode >> 6) == '0;

   generate
      if (TABLE_ID == 1) begin : g_first
         always_comb begin
            target = '0;
            if (upper_clear) begin
               case (op_low)
                  OPC_RTYPE: target = ST_W'(6);
                  OPC_JUMP:  target = ST_W'(9);
                  OPC_BEQ:   target = ST_W'(8);
                  OPC_LOAD:  target = ST_W'(2);
                  OPC_STORE: target = ST_W'(2);
                  default:   target = '0;
               endcase
            end
         end
      end else if (TABLE_ID == 2) begin : g_second
         always_comb begin
            target = '0;
            if (upper_clear) begin
               case (op_low)
                  OPC_LOAD:  target = ST_W'(3);
                  OPC_STORE: target = ST_W'(5);
                  default:   target = '0;
               endcase
            end
         end
      end else begin : g_bad
         $error("mseq_dispatch: TABLE_ID must be 1 or 2");
         assign target = '0;
      end
   endgenerate
endmodule

// File: rtl/mseq_next_mux.sv
module mseq_next_mux
   import mseq_pkg::*;
#(
   parameter int unsigned ST_W = 4
) (
   input  addr_sel_e       sel,
   input  logic [ST_W-1:0] cur,
   input  logic [ST_W-1:0] disp_a,
   input  logic [ST_W-1:0] disp_b,
   output logic [ST_W-1:0] nxt
);
   logic [ST_W-1:0] cur_plus;

   assign cur_plus = cur + ST_W'(1);

   always_comb begin
      case (sel)
         SEL_DISP_A: nxt = disp_a;
         SEL_DISP_B: nxt = disp_b;
         SEL_INCR:   nxt = cur_plus;
         default:    nxt = '0;
      endcase
   end
endmodule

// File: rtl/mseq_sequencer.sv
module mseq_sequencer
   import mseq_pkg::*;
#(
   parameter int unsigned ST_W = 4,
   parameter int unsigned OP_W = 6
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [OP_W-1:0] opcode,
   output logic [ST_W-1:0] state_o,
   output logic [1:0]      addr_ctrl_o
);
   localparam int unsigned MAX_STATE = 9;

   generate
      if (ST_W < 4 || (1 << ST_W) <= MAX_STATE) begin : g_chk_st
         $error("mseq_sequencer: ST_W too small for the state map");
      end
      if (OP_W < 6) begin : g_chk_op
         $error("mseq_sequencer: OP_W must be at least 6");
      end
   endgenerate

   logic [ST_W-1:0] state_q;
   logic [ST_W-1:0] state_d;
   logic [ST_W-1:0] tgt_a;
   logic [ST_W-1:0] tgt_b;
   addr_sel_e       sel;

   mseq_ctrl_store #(.ST_W(ST_W)) u_store (
      .state (state_q),
      .sel   (sel)
   );

   mseq_dispatch #(.ST_W(ST_W), .OP_W(OP_W), .TABLE_ID(1)) u_disp_a (
      .opcode (opcode),
      .target (tgt_a)
   );

   mseq_dispatch #(.ST_W(ST_W), .OP_W(OP_W), .TABLE_ID(2)) u_disp_b (
      .opcode (opcode),
      .target (tgt_b)
   );

   mseq_next_mux #(.ST_W(ST_W)) u_mux (
      .sel    (sel),
      .cur    (state_q),
      .disp_a (tgt_a),
      .disp_b (tgt_b),
      .nxt    (state_d)
   );

   always_ff @(posedge clk) begin
      if (rst) state_q <= '0;
      else     state_q <= state_d;
   end

   assign state_o     = state_q;
   assign addr_ctrl_o = sel;
endmodule

// File: rtl/mseq_sequencer_chk.sv
module mseq_sequencer_chk #(
   parameter int unsigned ST_W = 4,
   parameter int unsigned OP_W = 6
) (
   input logic            clk,
   input logic            rst,
   input logic [OP_W-1:0] opcode,
   input logic [ST_W-1:0] state_o,
   input logic [1:0]      addr_ctrl_o
);
   logic op_in_a;
   assign op_in_a = (opcode == OP_W'(6'b000000)) || (opcode == OP_W'(6'b000010)) ||
                    (opcode == OP_W'(6'b000100)) || (opcode == OP_W'(6'b100011)) ||
                    (opcode == OP_W'(6'b101011));

   // R1
   reset_to_zero_chk: assert property (@(posedge clk) rst |=> state_o == '0);

   // R2
   dispatch_codes_chk: assert property (@(posedge clk) disable iff (rst)
      (state_o == ST_W'(1) |-> addr_ctrl_o == 2'd1) and (state_o == ST_W'(2) |-> addr_ctrl_o == 2'd2));

   // R3
   incr_step_chk: assert property (@(posedge clk) disable iff (rst)
      addr_ctrl_o == 2'd3 |=> state_o == $past(state_o) + ST_W'(1));

   // R4
   zero_return_chk: assert property (@(posedge clk) disable iff (rst)
      addr_ctrl_o == 2'd0 |=> state_o == '0);

   // R5
   first_load_chk: assert property (@(posedge clk) disable iff (rst)
      (state_o == ST_W'(1) && opcode == OP_W'(6'b100011)) |=> state_o == ST_W'(2));

   // R6
   second_store_chk: assert property (@(posedge clk) disable iff (rst)
      (state_o == ST_W'(2) && opcode == OP_W'(6'b101011)) |=> state_o == ST_W'(5));

   // R7
   first_miss_chk: assert property (@(posedge clk) disable iff (rst)
      (state_o == ST_W'(1) && !op_in_a) |=> state_o == '0);
endmodule

bind mseq_sequencer mseq_sequencer_chk #(.ST_W(ST_W), .OP_W(OP_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .opcode      (opcode),
   .state_o     (state_o),
   .addr_ctrl_o (addr_ctrl_o)
);

// File: tb/sim_mseq_sequencer.sv
module sim_mseq_sequencer;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [5:0] opcode = 6'b000000;
   logic [3:0] state_o;
   logic [1:0] addr_ctrl_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   typedef struct {
      logic [3:0] st;
      string      tag;
   } exp_t;

   exp_t sb_q[$];

   always #10 clk = ~clk;

   mseq_sequencer u0 (
      .clk         (clk),
      .rst         (rst),
      .opcode      (opcode),
      .state_o     (state_o),
      .addr_ctrl_o (addr_ctrl_o)
   );

   // R2 table of codes per state
   function automatic logic [1:0] code_of(input logic [3:0] s);
      case (s)
         4'd0, 4'd3, 4'd6: return 2'd3;
         4'd1:             return 2'd1;
         4'd2:             return 2'd2;
         default:          return 2'd0;
      endcase
   endfunction

   // driver: opcode applied to the current state, expected next state queued
   task automatic step(input logic [5:0] op, input logic [3:0] nxt, input string tag);
      exp_t e;
      opcode = op;
      @(posedge clk);
      #2;
      e.st  = nxt;
      e.tag = tag;
      sb_q.push_back(e);
   endtask

   // monitor
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         n_cmp++;
         if (state_o !== e.st) begin
            n_bad++;
            $display("FAIL %s: state actual=%0d expected=%0d", e.tag, state_o, e.st);
         end
         n_cmp++;
         if (addr_ctrl_o !== code_of(e.st)) begin
            n_bad++;
            $display("FAIL R2 (%s): code actual=%0d expected=%0d", e.tag, addr_ctrl_o, code_of(e.st));
         end
      end
   end

   initial begin
      for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      step(6'b000000, 4'd0, "R1 reset hold");
      step(6'b111111, 4'd0, "R1 reset hold");
      rst = 1'b0;
      // R8 load path, junk opcode in ignored states (R9)
      step(6'b100011, 4'd1, "R8 lw 0->1");
      step(6'b100011, 4'd2, "R5 lw 1->2");
      step(6'b100011, 4'd3, "R6 lw 2->3");
      step(6'b000100, 4'd4, "R9 lw 3->4 opcode ignored");
      step(6'b111111, 4'd0, "R4 lw 4->0");
      // store path
      step(6'b101011, 4'd1, "R8 sw 0->1");
      step(6'b101011, 4'd2, "R5 sw 1->2");
      step(6'b101011, 4'd5, "R6 sw 2->5");
      step(6'b101011, 4'd0, "R4 sw 5->0");
      // R-type path
      step(6'b000000, 4'd1, "R8 rtype 0->1");
      step(6'b000000, 4'd6, "R5 rtype 1->6");
      step(6'b000010, 4'd7, "R3 R9 rtype 6->7");
      step(6'b000000, 4'd0, "R4 rtype 7->0");
      // branch path
      step(6'b000100, 4'd1, "R8 beq 0->1");
      step(6'b000100, 4'd8, "R5 beq 1->8");
      step(6'b000100, 4'd0, "R4 beq 8->0");
      // jump path
      step(6'b000010, 4'd1, "R8 j 0->1");
      step(6'b000010, 4'd9, "R5 j 1->9");
      step(6'b000010, 4'd0, "R4 j 9->0");
      // R7 miss in first table
      step(6'b111111, 4'd1, "R3 0->1");
      step(6'b111111, 4'd0, "R7 first table miss");
      // R7 miss in second table: enter state 2 with load, then swap opcode
      step(6'b100011, 4'd1, "R3 0->1");
      step(6'b100011, 4'd2, "R5 1->2");
      step(6'b000000, 4'd0, "R7 second table miss");
      // R1 reset mid-instruction
      step(6'b100011, 4'd1, "R3 0->1");
      step(6'b100011, 4'd2, "R5 1->2");
      step(6'b100011, 4'd3, "R6 2->3");
      rst = 1'b1;
      step(6'b100011, 4'd0, "R1 reset from state 3");
      rst = 1'b0;
      step(6'b000000, 4'd1, "R3 after reset 0->1");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule